// File: doc/BRIEF.md
# SuperPixel Matrix Filling Chain

This block gathers the SuperPixels of one sensor that have at least one active neighbour, and sorts them into small 3×3 neighbourhoods for a later cluster-pattern stage. Each SuperPixel is a 2-pixel-wide, 4-pixel-tall patch. Its eight hit bits are numbered `b = py*2 + px`, with `px` in 0..1 and `py` in 0..3. SuperPixels enter the head of a chain of matrix cells, one per clock at most, and move one cell per clock. A cell that holds nothing takes the first SuperPixel that reaches it as its centre. At that moment it works out the eight surrounding SuperPixel coordinates. Any later SuperPixel whose coordinates equal one of those slots is written into that slot. Any other SuperPixel goes on to the next cell.

An end-of-event token follows the event's SuperPixels down the chain. As it passes each cell, the cell copies its anchor and its contents into a snapshot register and returns to the empty state. The snapshot stays on the outputs until the next token reaches that cell. A SuperPixel that leaves the last cell without a home is dropped and reported. A separate pulse marks the moment the token leaves the chain. At that point every snapshot belongs to the event that just ended.

Top module: `sp_matrix_chain`

## Requirements
- R1: After reset, every snapshot reports not used and an all-zero image, and `overflow` and `eoe_done` are low.
- R2: The first SuperPixel to reach an empty cell claims that cell. The cell's snapshot anchor equals that SuperPixel's (column, row), and its hits land in the centre slot (slot 4).
- R3: A SuperPixel at anchor offset (dc, dr), with both in −1..1, is ORed into slot `(dr+1)*3 + (dc+1)`. In the 6-wide by 12-tall snapshot image, hit bit b of slot s lands at pixel x = `(s%3)*2 + b%2`, y = `(s/3)*4 + b/2`, which is image bit `y*6 + x`.
- R4: A SuperPixel that matches no slot of a claimed cell moves to the next cell. It is placed in the first cell along the chain that either matches it or is still empty.
- R5: Slot coordinates that lie outside the sensor (column outside 0..SENSOR_COLS−1 or row outside 0..SENSOR_ROWS−1) never match, including coordinates that would wrap around the coordinate width.
- R6: A SuperPixel that passes the last cell unplaced is dropped and raises `overflow` for exactly one cycle.
- R7: When the token passes a cell, the cell's snapshot takes the cell's contents, and the cell becomes empty for the next event. The snapshot then holds until the next token passes.
- R8: `eoe_done` is high for exactly one cycle, starting N_CELLS clock edges after the edge at which `eoe` is sampled (counting that edge as the first).
- R9: Several SuperPixels that map to the same slot in one event are ORed together in that slot.
- R10: A SuperPixel presented in the same cycle as `eoe` belongs to the event that the token closes.
- R11: SuperPixels are accepted on consecutive clock cycles with no gaps, and each is placed as if the earlier ones had already settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_valid | input | 1 | A SuperPixel is presented this cycle |
| sp_col | input | COL_W | SuperPixel column coordinate |
| sp_row | input | ROW_W | SuperPixel row coordinate |
| sp_hits | input | 8 | Hit map, bit py*2+px |
| eoe | input | 1 | End-of-event token enters the chain |
| overflow | output | 1 | An unplaced SuperPixel left the last cell |
| eoe_done | output | 1 | The token left the last cell |
| rd_used | output | N_CELLS | Per-cell snapshot: cell was claimed |
| rd_col | output | N_CELLS*COL_W | Per-cell snapshot anchor column |
| rd_row | output | N_CELLS*ROW_W | Per-cell snapshot anchor row |
| rd_image | output | N_CELLS*72 | Per-cell 6×12 pixel image, bit y*6+x |

## Verification
The bench builds the chain with four cells on an 8-column by 4-row sensor. This makes the coordinate widths 3 and 2 bits, so every neighbour offset off the sensor edge wraps onto a real sensor position. That lets the bench test the out-of-sensor rejection directly. Every anchor position on the sensor is swept, each with all eight surrounding offsets, and the bench model decides cell by cell where each SuperPixel goes. With only four cells, overflow is reached with a handful of SuperPixels. Duplicated slots, a SuperPixel sharing its cycle with the token, and snapshot hold are also tested.

// File: rtl/sp_chain_pkg.sv
package sp_chain_pkg;
  localparam int HIT_W     = 8;   // one SuperPixel: 2 wide x 4 tall
  localparam int GRID      = 3;   // 3x3 SuperPixels per matrix
  localparam int SLOTS     = GRID * GRID;
  localparam int CENTRE    = SLOTS / 2;
  localparam int SLOT_BITS = SLOTS * HIT_W;
  localparam int IMG_COLS  = GRID * 2;
  localparam int IMG_BITS  = SLOT_BITS;

  // pixel index inside the 6x12 image for hit bit b of slot s
  function automatic int img_bit(input int s, input int b);
    int x, y;
    x = (s % GRID) * 2 + (b % 2);
    y = (s / GRID) * 4 + (b / 2);
    return y * IMG_COLS + x;
  endfunction
endpackage

// File: rtl/sp_image_pack.sv
module sp_image_pack
  import sp_chain_pkg::*;
(
  input  logic [SLOT_BITS-1:0] slots,
  output logic [IMG_BITS-1:0]  image
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar b = 0; b < HIT_W; b++) begin : g_bit
      localparam int IDX = img_bit(s, b);
      assign image[IDX] = slots[s*HIT_W + b];
    end
  end
endmodule

// File: rtl/sp_matrix_cell.sv
module sp_matrix_cell
  import sp_chain_pkg::*;
#(
  parameter int SENSOR_COLS = 128,
  parameter int SENSOR_ROWS = 64,
  parameter int COL_W       = 7,
  parameter int ROW_W       = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 i_v,
  input  logic [COL_W-1:0]     i_col,
  input  logic [ROW_W-1:0]     i_row,
  input  logic [HIT_W-1:0]     i_hits,
  input  logic                 i_tok,
  output logic                 o_v,
  output logic [COL_W-1:0]     o_col,
  output logic [ROW_W-1:0]     o_row,
  output logic [HIT_W-1:0]     o_hits,
  output logic                 o_tok,
  output logic                 snap_used,
  output logic [COL_W-1:0]     snap_col,
  output logic [ROW_W-1:0]     snap_row,
  output logic [SLOT_BITS-1:0] snap_slots,
  output logic                 used,
  output logic                 claim
);
  // slot k sits at column offset k%3-1 and row offset k/3-1 from the centre
  function automatic logic slot_inside(input logic [COL_W-1:0] c,
                                       input logic [ROW_W-1:0] r, input int k);
    int cc, rr;
    cc = int'(c) + (k % GRID) - 1;
    rr = int'(r) + (k / GRID) - 1;
    return (cc >= 0) && (cc < SENSOR_COLS) && (rr >= 0) && (rr < SENSOR_ROWS);
  endfunction

  function automatic logic [COL_W-1:0] slot_col(input logic [COL_W-1:0] c, input int k);
    return c + COL_W'(k % GRID) - COL_W'(1);
  endfunction

  function automatic logic [ROW_W-1:0] slot_row(input logic [ROW_W-1:0] r, input int k);
    return r + ROW_W'(k / GRID) - ROW_W'(1);
  endfunction

  logic               used_q;
  logic [COL_W-1:0]   ctr_col_q;
  logic [ROW_W-1:0]   ctr_row_q;
  logic [COL_W-1:0]   nb_col_q [SLOTS];
  logic [ROW_W-1:0]   nb_row_q [SLOTS];
  logic [SLOTS-1:0]   nb_ok_q;
  logic [HIT_W-1:0]   slot_q   [SLOTS];

  logic [SLOTS-1:0]   match;
  logic               place, fwd, used_n;
  logic [COL_W-1:0]   col_n;
  logic [ROW_W-1:0]   row_n;
  logic [HIT_W-1:0]   slot_n   [SLOTS];

  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      match[k] = used_q && nb_ok_q[k] && (nb_col_q[k] == i_col) && (nb_row_q[k] == i_row);
    end
    claim  = i_v && !used_q;
    place  = i_v && used_q && (|match);
    fwd    = i_v && used_q && !(|match);
    used_n = used_q || claim;
    col_n  = claim ? i_col : ctr_col_q;
    row_n  = claim ? i_row : ctr_row_q;
    for (int k = 0; k < SLOTS; k++) begin
      if (claim)                 slot_n[k] = (k == CENTRE) ? i_hits : '0;
      else if (place && match[k]) slot_n[k] = slot_q[k] | i_hits;
      else                       slot_n[k] = slot_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q    <= 1'b0;
      ctr_col_q <= '0;
      ctr_row_q <= '0;
      nb_ok_q   <= '0;
      for (int k = 0; k < SLOTS; k++) begin
        nb_col_q[k] <= '0;
        nb_row_q[k] <= '0;
        slot_q[k]   <= '0;
      end
      snap_used  <= 1'b0;
      snap_col   <= '0;
      snap_row   <= '0;
      snap_slots <= '0;
      o_v        <= 1'b0;
      o_col      <= '0;
      o_row      <= '0;
      o_hits     <= '0;
      o_tok      <= 1'b0;
    end else begin
      if (claim) begin
        for (int k = 0; k < SLOTS; k++) begin
          nb_col_q[k] <= slot_col(i_col, k);
          nb_row_q[k] <= slot_row(i_row, k);
          nb_ok_q[k]  <= slot_inside(i_col, i_row, k);
        end
      end
      if (i_tok) begin
        snap_used <= used_n;
        snap_col  <= col_n;
        snap_row  <= row_n;
        for (int k = 0; k < SLOTS; k++) begin
          snap_slots[k*HIT_W +: HIT_W] <= slot_n[k];
          slot_q[k] <= '0;
        end
        used_q <= 1'b0;
      end else begin
        used_q <= used_n;
        for (int k = 0; k < SLOTS; k++) slot_q[k] <= slot_n[k];
      end
      ctr_col_q <= col_n;
      ctr_row_q <= row_n;
      o_v    <= fwd;
      o_col  <= i_col;
      o_row  <= i_row;
      o_hits <= i_hits;
      o_tok  <= i_tok;
    end
  end

  assign used = used_q;
endmodule

// File: rtl/sp_matrix_chain.sv
module sp_matrix_chain
  import sp_chain_pkg::*;
#(
  parameter int N_CELLS     = 20,
  parameter int SENSOR_COLS = 128,
  parameter int SENSOR_ROWS = 64,
  parameter int COL_W       = $clog2(SENSOR_COLS),
  parameter int ROW_W       = $clog2(SENSOR_ROWS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sp_valid,
  input  logic [COL_W-1:0]            sp_col,
  input  logic [ROW_W-1:0]            sp_row,
  input  logic [7:0]                  sp_hits,
  input  logic                        eoe,
  output logic                        overflow,
  output logic                        eoe_done,
  output logic [N_CELLS-1:0]          rd_used,
  output logic [N_CELLS*COL_W-1:0]    rd_col,
  output logic [N_CELLS*ROW_W-1:0]    rd_row,
  output logic [N_CELLS*72-1:0]       rd_image
);
  logic             v_c    [N_CELLS+1];
  logic [COL_W-1:0] col_c  [N_CELLS+1];
  logic [ROW_W-1:0] row_c  [N_CELLS+1];
  logic [HIT_W-1:0] hits_c [N_CELLS+1];
  logic             tok_c  [N_CELLS+1];

  // named events for the checker
  logic [N_CELLS-1:0] tok_at;
  logic [N_CELLS-1:0] used_vec;
  logic [N_CELLS-1:0] claim_vec;

  assign v_c[0]    = sp_valid;
  assign col_c[0]  = sp_col;
  assign row_c[0]  = sp_row;
  assign hits_c[0] = sp_hits;
  assign tok_c[0]  = eoe;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic [SLOT_BITS-1:0] slots;

    sp_matrix_cell #(
      .SENSOR_COLS(SENSOR_COLS), .SENSOR_ROWS(SENSOR_ROWS),
      .COL_W(COL_W), .ROW_W(ROW_W)
    ) cell_i (
      .clk(clk), .rst_n(rst_n),
      .i_v(v_c[i]), .i_col(col_c[i]), .i_row(row_c[i]), .i_hits(hits_c[i]), .i_tok(tok_c[i]),
      .o_v(v_c[i+1]), .o_col(col_c[i+1]), .o_row(row_c[i+1]), .o_hits(hits_c[i+1]),
      .o_tok(tok_c[i+1]),
      .snap_used(rd_used[i]),
      .snap_col(rd_col[i*COL_W +: COL_W]),
      .snap_row(rd_row[i*ROW_W +: ROW_W]),
      .snap_slots(slots),
      .used(used_vec[i]),
      .claim(claim_vec[i])
    );

    sp_image_pack pack_i (
      .slots(slots),
      .image(rd_image[i*IMG_BITS +: IMG_BITS])
    );

    assign tok_at[i] = tok_c[i];
  end

  assign overflow = v_c[N_CELLS];
  assign eoe_done = tok_c[N_CELLS];

  logic unused_tail;
  assign unused_tail = ^{col_c[N_CELLS], row_c[N_CELLS], hits_c[N_CELLS]};
endmodule

// File: rtl/sp_matrix_chain_chk.sv
module sp_matrix_chain_chk #(
  parameter int N_CELLS = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CELLS-1:0] tok_at,
  input logic [N_CELLS-1:0] used_vec,
  input logic [N_CELLS-1:0] claim_vec,
  input logic               overflow,
  input logic               eoe_done
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
    // R7: a passing token leaves the cell empty
    a_r7_cleared_after_token: assert property (@(posedge clk) disable iff (!rst_n)
      tok_at[i] |=> !used_vec[i]);

    // R2: a claim outside a token cycle leaves the cell held
    a_r2_claim_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_vec[i] && !tok_at[i]) |=> used_vec[i]);

    if (i < N_CELLS - 1) begin : g_link
      // R7: the token advances one cell per clock
      a_r7_token_walks: assert property (@(posedge clk) disable iff (!rst_n)
        tok_at[i] |=> tok_at[i+1]);

      // R4: cells are claimed in chain order
      a_r4_fill_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (used_vec[i+1] && !tok_at[i+1]) |-> used_vec[i]);
    end
  end

  // R8: the done pulse follows the token out of the last cell
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    tok_at[N_CELLS-1] |=> eoe_done);

  // R6: overflow only when the last cell was already claimed
  a_r6_overflow_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(used_vec[N_CELLS-1]));
endmodule

bind sp_matrix_chain sp_matrix_chain_chk #(.N_CELLS(N_CELLS)) chk_i (
  .clk(clk), .rst_n(rst_n), .tok_at(tok_at), .used_vec(used_vec),
  .claim_vec(claim_vec), .overflow(overflow), .eoe_done(eoe_done)
);

// File: tb/sp_matrix_chain_tb_top.sv
module sp_matrix_chain_tb_top;
  localparam int NC = 4;
  localparam int SC = 8;
  localparam int SR = 4;
  localparam int CW = 3;
  localparam int RW = 2;
  localparam int IB = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sp_valid = 1'b0;
  logic [CW-1:0] sp_col = '0;
  logic [RW-1:0] sp_row = '0;
  logic [7:0] sp_hits = '0;
  logic eoe = 1'b0;
  logic overflow, eoe_done;
  logic [NC-1:0] rd_used;
  logic [NC*CW-1:0] rd_col;
  logic [NC*RW-1:0] rd_row;
  logic [NC*IB-1:0] rd_image;

  always #2 clk = ~clk;  // 4 ns period

  sp_matrix_chain #(.N_CELLS(NC), .SENSOR_COLS(SC), .SENSOR_ROWS(SR)) dut_i (
    .clk(clk), .rst_n(rst_n), .sp_valid(sp_valid), .sp_col(sp_col), .sp_row(sp_row),
    .sp_hits(sp_hits), .eoe(eoe), .overflow(overflow), .eoe_done(eoe_done),
    .rd_used(rd_used), .rd_col(rd_col), .rd_row(rd_row), .rd_image(rd_image)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ov_seen = 0;
  int ov_exp = 0;

  bit          m_used [NC];
  int          m_col  [NC];
  int          m_row  [NC];
  logic [IB-1:0] m_img [NC];

  always @(negedge clk) if (rst_n && overflow) ov_seen++;

  task automatic check(input bit ok, input string req, input logic [IB-1:0] act,
                       input logic [IB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // image position of hit bit b in 3x3 slot s: x across, y down, 6 pixels per row
  function automatic int pix(input int s, input int b);
    int px, py;
    px = 2 * (s % 3) + (b & 1);
    py = 4 * (s / 3) + (b >> 1);
    return 6 * py + px;
  endfunction

  function automatic logic [IB-1:0] spread(input int s, input logic [7:0] h);
    logic [IB-1:0] r = '0;
    for (int b = 0; b < 8; b++) if (h[b]) r[pix(s, b)] = 1'b1;
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NC; i++) begin
      m_used[i] = 0; m_col[i] = 0; m_row[i] = 0; m_img[i] = '0;
    end
  endtask

  task automatic model_sp(input int c, input int r, input logic [7:0] h);
    for (int i = 0; i < NC; i++) begin
      if (!m_used[i]) begin
        m_used[i] = 1; m_col[i] = c; m_row[i] = r; m_img[i] = spread(4, h);
        return;
      end
      if (c - m_col[i] >= -1 && c - m_col[i] <= 1 && r - m_row[i] >= -1 && r - m_row[i] <= 1) begin
        m_img[i] = m_img[i] | spread((r - m_row[i] + 1) * 3 + (c - m_col[i] + 1), h);
        return;
      end
    end
    ov_exp++;
  endtask

  task automatic cyc(input bit v, input int c, input int r, input logic [7:0] h, input bit t);
    @(negedge clk);
    sp_valid = v; sp_col = CW'(c); sp_row = RW'(r); sp_hits = h; eoe = t;
    if (v) model_sp(c, r, h);
  endtask

  task automatic compare_snap(input string req);
    for (int i = 0; i < NC; i++) begin
      check(rd_used[i] == m_used[i], req, IB'(rd_used[i]), IB'(m_used[i]));
      if (m_used[i]) begin
        check(int'(rd_col[i*CW +: CW]) == m_col[i], "R2 anchor col",
              IB'(rd_col[i*CW +: CW]), IB'(m_col[i]));
        check(int'(rd_row[i*RW +: RW]) == m_row[i], "R2 anchor row",
              IB'(rd_row[i*RW +: RW]), IB'(m_row[i]));
      end
      check(rd_image[i*IB +: IB] == m_img[i], req, rd_image[i*IB +: IB], m_img[i]);
    end
  endtask

  task automatic close_event(input bit with_sp, input int c, input int r,
                             input logic [7:0] h, input string req);
    cyc(with_sp, c, r, h, 1'b1);
    for (int k = 0; k < NC - 1; k++) begin
      @(negedge clk);
      sp_valid = 1'b0; eoe = 1'b0;
      check(eoe_done == 1'b0, "R8 early", IB'(eoe_done), IB'(0));
    end
    @(negedge clk);
    sp_valid = 1'b0; eoe = 1'b0;
    check(eoe_done == 1'b1, "R8 on time", IB'(eoe_done), IB'(1));
    @(negedge clk);
    check(eoe_done == 1'b0, "R8 one cycle", IB'(eoe_done), IB'(0));
    repeat (2) @(negedge clk);
    check(ov_seen == ov_exp, "R6 overflow count", IB'(ov_seen), IB'(ov_exp));
    compare_snap(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rd_used == '0, "R1 used", IB'(rd_used), IB'(0));
    check(rd_image == '0, "R1 image", rd_image[IB-1:0], IB'(0));
    check(overflow == 1'b0 && eoe_done == 1'b0, "R1 flags", IB'({overflow, eoe_done}), IB'(0));

    // R3 R5 R11: every anchor with all eight offsets, wrapped at the sensor edge
    for (int c = 0; c < SC; c++) begin
      for (int r = 0; r < SR; r++) begin
        cyc(1'b1, c, r, 8'((c * 7 + r * 13) % 255 + 1), 1'b0);
        for (int k = 0; k < 9; k++) begin
          if (k != 4) begin
            cyc(1'b1, (c + k % 3 - 1 + SC) % SC, (r + k / 3 - 1 + SR) % SR,
                8'(((k + 1) * 29 + c * 7 + r * 13) % 255 + 1), 1'b0);
          end
        end
        close_event(1'b0, 0, 0, 8'h00, "R3 R5 R11 sweep");
        model_reset();
      end
    end

    // R9: repeated slots are ORed
    cyc(1'b1, 4, 2, 8'h01, 1'b0);
    cyc(1'b1, 4, 2, 8'h10, 1'b0);
    cyc(1'b1, 5, 3, 8'h03, 1'b0);
    cyc(1'b1, 5, 3, 8'h0C, 1'b0);
    close_event(1'b0, 0, 0, 8'h00, "R9 repeat");
    model_reset();

    // R4 R6: six far-apart SuperPixels into four cells
    cyc(1'b1, 0, 0, 8'h11, 1'b0);
    cyc(1'b1, 3, 0, 8'h22, 1'b0);
    cyc(1'b1, 6, 0, 8'h44, 1'b0);
    cyc(1'b1, 0, 3, 8'h88, 1'b0);
    cyc(1'b1, 3, 3, 8'hF0, 1'b0);
    cyc(1'b1, 6, 3, 8'h0F, 1'b0);
    close_event(1'b0, 0, 0, 8'h00, "R4 R6 chain order");
    model_reset();

    // R10: SuperPixel sharing the token's cycle
    cyc(1'b1, 2, 1, 8'h81, 1'b0);
    close_event(1'b1, 3, 2, 8'h42, "R10 same cycle");

    // R7: snapshot holds while idle
    repeat (5) @(negedge clk);
    compare_snap("R7 hold");
    model_reset();

    // R7: cells start empty for the next event
    cyc(1'b1, 7, 3, 8'h5A, 1'b0);
    close_event(1'b0, 0, 0, 8'h00, "R7 cleared");
    model_reset();

    report();
  end
endmodule